// File: doc/BRIEF.md
# Dual-Port Configuration Space with Base Address Decode

This block keeps a small configuration register space of sixteen 32-bit words (64 bytes). Two independent ports reach the same storage. One is the bus-target port, used by configuration cycles from the system bus. The other is the local module port, which reaches the registers only while its chip-select input is high. Writes are qualified per byte lane by active-low byte enables. Reads return the addressed word on the clock edge after the request.

Six of the words are base address registers. Bit 0 of each one chooses between I/O space (1) and memory space (0). Every access offered on the decode inputs is compared against all six ranges. One clock later, a one-hot select vector names the range that was hit. Each range covers 2^BAR_SIZE_LOG2 bytes. The address bits below that size are hardwired to zero in the register.

When both ports write in the same cycle, a small arbiter gives the bus-target write the first slot and applies the module write on the following cycle. The arbiter has two states. In ARB_IDLE a module write goes straight to storage. The transition ARB_IDLE to ARB_DEFER happens on a write from both ports in the same cycle. In ARB_DEFER the pending module write is applied. The arbiter stays in ARB_DEFER when another module write arrives in that cycle. It returns to ARB_DEFER to ARB_IDLE otherwise.

Top module: `cfg_space_decode`

## Requirements
- R1: After reset, word 0 reads the read-only identity value ID_VALUE from either port, every other word reads zero, both read data outputs are zero and dec_sel is zero.
- R2: A bus-side access (pci_req high) writes when pci_we is high. A read (pci_we low) places the word's contents, as they stood before any write at that same edge, on pci_rdata one clock later. The module port behaves the same way using mod_cs as its strobe.
- R3: Bit k of a byte-enable input is active low and qualifies data bits 8k+7 down to 8k. Lanes whose enable bit is 1 keep their old contents.
- R4: While mod_cs is low, module-side writes have no effect and mod_rdata holds its previous value.
- R5: When both ports write in the same cycle, the bus-side write is stored at that edge and the module write is stored at the next edge, so a read in between sees only the bus-side value.
- R6: When a deferred module write and a new bus-side write to the same word land in the same cycle, the bus-side enabled lanes take priority.
- R7: In base address words 4 to 9, bit 0 is writable, bits BAR_SIZE_LOG2-1 down to 1 always read zero, and the bits above are writable. Words 1 and 15 are fully writable.
- R8: One clock after dec_valid, dec_sel bit i is high when the address equals base register i in every bit from BAR_SIZE_LOG2 upward and the access type matches. dec_sel is zero when dec_valid was low.
- R9: A base register with bit 0 set is hit only by accesses with dec_is_mem low (I/O). One with bit 0 clear is hit only by accesses with dec_is_mem high (memory).
- R10: A base register whose value is all zeros never raises its select bit.
- R11: When several ranges match, only the bit of the lowest-numbered base register is raised, so dec_sel has at most one bit set.
- R12: Words 2, 3 and 10 to 14 read zero and ignore writes. Writes to word 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pci_req | input | 1 | Bus-side configuration access strobe |
| pci_we | input | 1 | Bus-side write (1) or read (0) |
| pci_word | input | 4 | Bus-side word index |
| pci_be_n | input | 4 | Bus-side byte enables, active low |
| pci_wdata | input | 32 | Bus-side write data |
| pci_rdata | output | 32 | Bus-side read data, registered |
| mod_cs | input | 1 | Module-side configuration chip select and access strobe |
| mod_we | input | 1 | Module-side write (1) or read (0) |
| mod_word | input | 4 | Module-side word index |
| mod_be_n | input | 4 | Module-side byte enables, active low |
| mod_wdata | input | 32 | Module-side write data |
| mod_rdata | output | 32 | Module-side read data, registered |
| dec_valid | input | 1 | Address presented for range decode |
| dec_addr | input | 32 | Address to decode |
| dec_is_mem | input | 1 | Access type: 1 memory, 0 I/O |
| dec_sel | output | 6 | One-hot range select, registered |

## Verification
The bench builds the block with BAR_SIZE_LOG2 set to 4, so each range is only 16 bytes wide. This lets the last byte inside a range and the first byte past it be probed with small, readable addresses, and makes the hardwired low bits of a base register easy to see. A non-default ID_VALUE is passed so that the reset contents of word 0 cannot be mistaken for zero. NUM_BARS stays at 6, so the full select vector, the overlap priority and the untouched zero-valued ranges are all covered.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

    localparam int CFG_DW         = 32;
    localparam int CFG_LANES      = CFG_DW / 8;
    localparam int BAR_FIRST_WORD = 4;

    typedef enum logic {
        ARB_IDLE,
        ARB_DEFER
    } arb_state_e;

    // Writable-bit mask of word w; zero marks a read-only or absent word.
    function automatic logic [CFG_DW-1:0] word_wmask(int w, int num_words,
                                                     int num_bars, int size_log2);
        logic [CFG_DW-1:0] m;
        m = '0;
        if (w == 1 || w == num_words - 1) begin
            m = '1;
        end else if (w >= BAR_FIRST_WORD && w < BAR_FIRST_WORD + num_bars) begin
            m = '1;
            m = m << size_log2;
            m[0] = 1'b1;
        end
        return m;
    endfunction

    // Overlay enabled byte lanes of data onto cur.
    function automatic logic [CFG_DW-1:0] merge_lanes(logic [CFG_DW-1:0] cur,
                                                      logic [CFG_DW-1:0] data,
                                                      logic [CFG_LANES-1:0] be_n);
        logic [CFG_DW-1:0] r;
        r = cur;
        for (int k = 0; k < CFG_LANES; k++) begin
            if (!be_n[k]) r[k*8 +: 8] = data[k*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/cfg_wr_arb.sv
module cfg_wr_arb
    import cfg_space_pkg::*;
#(
    parameter int WW = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pci_wr,
    input  logic [WW-1:0]        pci_word,
    input  logic [CFG_LANES-1:0] pci_be_n,
    input  logic [CFG_DW-1:0]    pci_wdata,
    input  logic                 mod_wr,
    input  logic [WW-1:0]        mod_word,
    input  logic [CFG_LANES-1:0] mod_be_n,
    input  logic [CFG_DW-1:0]    mod_wdata,
    output logic                 a_en,
    output logic [WW-1:0]        a_word,
    output logic [CFG_LANES-1:0] a_be_n,
    output logic [CFG_DW-1:0]    a_data,
    output logic                 b_en,
    output logic [WW-1:0]        b_word,
    output logic [CFG_LANES-1:0] b_be_n,
    output logic [CFG_DW-1:0]    b_data
);

    arb_state_e state_q, state_d;
    logic                 defer_now;
    logic [WW-1:0]        pend_word;
    logic [CFG_LANES-1:0] pend_be_n;
    logic [CFG_DW-1:0]    pend_data;

    always_comb begin
        state_d   = state_q;
        defer_now = 1'b0;
        unique case (state_q)
            ARB_IDLE: begin
                if (pci_wr && mod_wr) begin
                    state_d   = ARB_DEFER;
                    defer_now = 1'b1;
                end
            end
            ARB_DEFER: begin
                if (mod_wr) begin
                    state_d   = ARB_DEFER;
                    defer_now = 1'b1;
                end else begin
                    state_d = ARB_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ARB_IDLE;
            pend_word <= '0;
            pend_be_n <= '1;
            pend_data <= '0;
        end else begin
            state_q <= state_d;
            if (defer_now) begin
                pend_word <= mod_word;
                pend_be_n <= mod_be_n;
                pend_data <= mod_wdata;
            end
        end
    end

    always_comb begin
        a_en   = pci_wr;
        a_word = pci_word;
        a_be_n = pci_be_n;
        a_data = pci_wdata;
        unique case (state_q)
            ARB_IDLE: begin
                b_en   = mod_wr && !pci_wr;
                b_word = mod_word;
                b_be_n = mod_be_n;
                b_data = mod_wdata;
            end
            ARB_DEFER: begin
                b_en   = 1'b1;
                b_word = pend_word;
                b_be_n = pend_be_n;
                b_data = pend_data;
            end
        endcase
    end

    // R5
    bus_first_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ARB_IDLE && pci_wr && mod_wr) |-> !b_en);

    // R5
    deferred_apply_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ARB_IDLE && pci_wr && mod_wr) |=>
            (b_en && b_word == $past(mod_word) && b_data == $past(mod_wdata)));

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfg_space_pkg::*;
#(
    parameter int              NUM_WORDS     = 16,
    parameter int              NUM_BARS      = 6,
    parameter int              BAR_SIZE_LOG2 = 8,
    parameter logic [31:0]     ID_VALUE      = 32'h5A17_C0DE,
    parameter int              WW            = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       a_en,
    input  logic [WW-1:0]              a_word,
    input  logic [CFG_LANES-1:0]       a_be_n,
    input  logic [CFG_DW-1:0]          a_data,
    input  logic                       b_en,
    input  logic [WW-1:0]              b_word,
    input  logic [CFG_LANES-1:0]       b_be_n,
    input  logic [CFG_DW-1:0]          b_data,
    input  logic                       pci_rd,
    input  logic [WW-1:0]              pci_rd_word,
    input  logic                       mod_rd,
    input  logic [WW-1:0]              mod_rd_word,
    output logic [CFG_DW-1:0]          pci_rdata,
    output logic [CFG_DW-1:0]          mod_rdata,
    output logic [NUM_BARS*CFG_DW-1:0] bar_flat
);

    logic [CFG_DW-1:0]    word_q [NUM_WORDS];
    logic [NUM_WORDS-1:0] impl_vec;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        localparam logic [CFG_DW-1:0] WMASK =
            word_wmask(w, NUM_WORDS, NUM_BARS, BAR_SIZE_LOG2);
        localparam logic [CFG_DW-1:0] RST_VAL = (w == 0) ? ID_VALUE : '0;
        logic [CFG_DW-1:0] q, nxt;

        always_comb begin
            nxt = q;
            // deferred or direct module write first, bus-side write last
            if (b_en && b_word == WW'(w)) nxt = merge_lanes(nxt, b_data, b_be_n);
            if (a_en && a_word == WW'(w)) nxt = merge_lanes(nxt, a_data, a_be_n);
        end

        always_ff @(posedge clk) begin
            if (rst) q <= RST_VAL;
            else     q <= (q & ~WMASK) | (nxt & WMASK);
        end

        assign word_q[w]   = q;
        assign impl_vec[w] = (WMASK != '0) || (w == 0);
    end

    for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
        assign bar_flat[b*CFG_DW +: CFG_DW] = word_q[BAR_FIRST_WORD + b];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pci_rdata <= '0;
            mod_rdata <= '0;
        end else begin
            if (pci_rd) pci_rdata <= word_q[pci_rd_word];
            if (mod_rd) mod_rdata <= word_q[mod_rd_word];
        end
    end

    // R12
    absent_word_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (pci_rd && !impl_vec[pci_rd_word]) |=> (pci_rdata == '0));

    // R1
    id_word_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (pci_rd && pci_rd_word == '0) |=> (pci_rdata == ID_VALUE));

endmodule

// File: rtl/cfg_bar_match.sv
module cfg_bar_match
    import cfg_space_pkg::*;
#(
    parameter int NUM_BARS      = 6,
    parameter int BAR_SIZE_LOG2 = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_BARS*CFG_DW-1:0] bar_flat,
    input  logic                       dec_valid,
    input  logic [CFG_DW-1:0]          dec_addr,
    input  logic                       dec_is_mem,
    output logic [NUM_BARS-1:0]        dec_sel
);

    localparam logic [CFG_DW-1:0] UPPER_MASK = {CFG_DW{1'b1}} << BAR_SIZE_LOG2;

    logic [NUM_BARS-1:0] hit, first_hit;

    for (genvar i = 0; i < NUM_BARS; i++) begin : g_cmp
        logic [CFG_DW-1:0] bar;
        assign bar    = bar_flat[i*CFG_DW +: CFG_DW];
        assign hit[i] = dec_valid
                     && (bar != '0)
                     && (bar[0] == !dec_is_mem)
                     && (((dec_addr ^ bar) & UPPER_MASK) == '0);
    end

    // isolate the lowest set bit
    assign first_hit = hit & (~hit + NUM_BARS'(1));

    always_ff @(posedge clk) begin
        if (rst) dec_sel <= '0;
        else     dec_sel <= first_hit;
    end

    // R11
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dec_sel));

    // R8
    sel_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (!dec_valid) |=> (dec_sel == '0));

endmodule

// File: rtl/cfg_space_decode.sv
module cfg_space_decode
    import cfg_space_pkg::*;
#(
    parameter int          NUM_WORDS     = 16,
    parameter int          NUM_BARS      = 6,
    parameter int          BAR_SIZE_LOG2 = 8,
    parameter logic [31:0] ID_VALUE      = 32'h5A17_C0DE
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         pci_req,
    input  logic                         pci_we,
    input  logic [$clog2(NUM_WORDS)-1:0] pci_word,
    input  logic [3:0]                   pci_be_n,
    input  logic [31:0]                  pci_wdata,
    output logic [31:0]                  pci_rdata,
    input  logic                         mod_cs,
    input  logic                         mod_we,
    input  logic [$clog2(NUM_WORDS)-1:0] mod_word,
    input  logic [3:0]                   mod_be_n,
    input  logic [31:0]                  mod_wdata,
    output logic [31:0]                  mod_rdata,
    input  logic                         dec_valid,
    input  logic [31:0]                  dec_addr,
    input  logic                         dec_is_mem,
    output logic [NUM_BARS-1:0]          dec_sel
);

    localparam int WW = $clog2(NUM_WORDS);

    logic                       pci_wr, pci_rd, mod_wr, mod_rd;
    logic                       a_en, b_en;
    logic [WW-1:0]              a_word, b_word;
    logic [CFG_LANES-1:0]       a_be_n, b_be_n;
    logic [CFG_DW-1:0]          a_data, b_data;
    logic [NUM_BARS*CFG_DW-1:0] bar_flat;

    assign pci_wr = pci_req && pci_we;
    assign pci_rd = pci_req && !pci_we;
    assign mod_wr = mod_cs && mod_we;
    assign mod_rd = mod_cs && !mod_we;

    cfg_wr_arb #(.WW(WW)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .pci_wr   (pci_wr),
        .pci_word (pci_word),
        .pci_be_n (pci_be_n),
        .pci_wdata(pci_wdata),
        .mod_wr   (mod_wr),
        .mod_word (mod_word),
        .mod_be_n (mod_be_n),
        .mod_wdata(mod_wdata),
        .a_en     (a_en),
        .a_word   (a_word),
        .a_be_n   (a_be_n),
        .a_data   (a_data),
        .b_en     (b_en),
        .b_word   (b_word),
        .b_be_n   (b_be_n),
        .b_data   (b_data)
    );

    cfg_regfile #(
        .NUM_WORDS    (NUM_WORDS),
        .NUM_BARS     (NUM_BARS),
        .BAR_SIZE_LOG2(BAR_SIZE_LOG2),
        .ID_VALUE     (ID_VALUE),
        .WW           (WW)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .a_en       (a_en),
        .a_word     (a_word),
        .a_be_n     (a_be_n),
        .a_data     (a_data),
        .b_en       (b_en),
        .b_word     (b_word),
        .b_be_n     (b_be_n),
        .b_data     (b_data),
        .pci_rd     (pci_rd),
        .pci_rd_word(pci_word),
        .mod_rd     (mod_rd),
        .mod_rd_word(mod_word),
        .pci_rdata  (pci_rdata),
        .mod_rdata  (mod_rdata),
        .bar_flat   (bar_flat)
    );

    cfg_bar_match #(
        .NUM_BARS     (NUM_BARS),
        .BAR_SIZE_LOG2(BAR_SIZE_LOG2)
    ) u_match (
        .clk       (clk),
        .rst       (rst),
        .bar_flat  (bar_flat),
        .dec_valid (dec_valid),
        .dec_addr  (dec_addr),
        .dec_is_mem(dec_is_mem),
        .dec_sel   (dec_sel)
    );

    // R4
    cs_low_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mod_cs) |=> $stable(mod_rdata));

endmodule

// File: tb/sim_cfg_space_decode.sv
module sim_cfg_space_decode;

    localparam logic [31:0] ID = 32'hC0FF_EE01;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pci_req = 0, pci_we = 0;
    logic [3:0]  pci_word = 0, pci_be_n = 4'hF;
    logic [31:0] pci_wdata = 0;
    logic [31:0] pci_rdata;
    logic        mod_cs = 0, mod_we = 0;
    logic [3:0]  mod_word = 0, mod_be_n = 4'hF;
    logic [31:0] mod_wdata = 0;
    logic [31:0] mod_rdata;
    logic        dec_valid = 0, dec_is_mem = 0;
    logic [31:0] dec_addr = 0;
    logic [5:0]  dec_sel;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    cfg_space_decode #(
        .NUM_WORDS(16), .NUM_BARS(6), .BAR_SIZE_LOG2(4), .ID_VALUE(ID)
    ) u0 (
        .clk(clk), .rst(rst),
        .pci_req(pci_req), .pci_we(pci_we), .pci_word(pci_word),
        .pci_be_n(pci_be_n), .pci_wdata(pci_wdata), .pci_rdata(pci_rdata),
        .mod_cs(mod_cs), .mod_we(mod_we), .mod_word(mod_word),
        .mod_be_n(mod_be_n), .mod_wdata(mod_wdata), .mod_rdata(mod_rdata),
        .dec_valid(dec_valid), .dec_addr(dec_addr), .dec_is_mem(dec_is_mem),
        .dec_sel(dec_sel)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pwr(logic [3:0] w, logic [3:0] be, logic [31:0] d);
        pci_req = 1; pci_we = 1; pci_word = w; pci_be_n = be; pci_wdata = d;
        @(negedge clk);
        pci_req = 0; pci_we = 0; pci_be_n = 4'hF;
    endtask

    task automatic prd(logic [3:0] w, output logic [31:0] d);
        pci_req = 1; pci_we = 0; pci_word = w;
        @(negedge clk);
        d = pci_rdata; pci_req = 0;
    endtask

    task automatic mwr(logic [3:0] w, logic [3:0] be, logic [31:0] d);
        mod_cs = 1; mod_we = 1; mod_word = w; mod_be_n = be; mod_wdata = d;
        @(negedge clk);
        mod_cs = 0; mod_we = 0; mod_be_n = 4'hF;
    endtask

    task automatic mrd(logic [3:0] w, output logic [31:0] d);
        mod_cs = 1; mod_we = 0; mod_word = w;
        @(negedge clk);
        d = mod_rdata; mod_cs = 0;
    endtask

    task automatic dec(logic [31:0] a, logic is_mem, output logic [5:0] s);
        dec_valid = 1; dec_addr = a; dec_is_mem = is_mem;
        @(negedge clk);
        s = dec_sel; dec_valid = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 pci_rdata reset", pci_rdata, 0);
        chk("R1 mod_rdata reset", mod_rdata, 0);
        chk("R1 dec_sel reset", {26'd0, dec_sel}, 0);
        prd(4'd0, d); chk("R1 id word bus", d, ID);
        mrd(4'd0, d); chk("R1 id word module", d, ID);
        prd(4'd1, d); chk("R1 word1 zero", d, 0);
        prd(4'd4, d); chk("R1 bar0 zero", d, 0);
    endtask

    task automatic t_basic();
        logic [31:0] d;
        pwr(4'd1, 4'h0, 32'hA5A5_1234);
        prd(4'd1, d); chk("R2 bus write/read", d, 32'hA5A5_1234);
        mrd(4'd1, d); chk("R2 module sees bus write", d, 32'hA5A5_1234);
        mwr(4'd15, 4'h0, 32'h0BAD_F00D);
        prd(4'd15, d); chk("R2 module write", d, 32'h0BAD_F00D);
    endtask

    task automatic t_lanes();
        logic [31:0] d;
        pwr(4'd15, 4'h0, 32'hFFFF_FFFF);
        pwr(4'd15, 4'b1010, 32'h0000_0000);
        prd(4'd15, d); chk("R3 bus lanes 0,2", d, 32'hFF00_FF00);
        mwr(4'd15, 4'b0111, 32'h12AB_CDEF);
        mrd(4'd15, d); chk("R3 module lane 3", d, 32'h1200_FF00);
    endtask

    task automatic t_cs_gate();
        logic [31:0] d;
        mrd(4'd1, d);
        chk("R4 reference read", d, 32'hA5A5_1234);
        mod_cs = 0; mod_we = 1; mod_word = 4'd1; mod_be_n = 4'h0; mod_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        mod_we = 0; mod_word = 4'd0;
        @(negedge clk);
        chk("R4 mod_rdata held", mod_rdata, 32'hA5A5_1234);
        mod_be_n = 4'hF;
        prd(4'd1, d); chk("R4 write without cs ignored", d, 32'hA5A5_1234);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        pci_req = 1; pci_we = 1; pci_word = 4'd1; pci_be_n = 4'h0; pci_wdata = 32'h1111_1111;
        mod_cs = 1; mod_we = 1; mod_word = 4'd1; mod_be_n = 4'b1100; mod_wdata = 32'h2222_2222;
        @(negedge clk);
        mod_cs = 0; mod_we = 0; mod_be_n = 4'hF;
        pci_we = 0; pci_be_n = 4'hF;
        @(negedge clk);
        d = pci_rdata; pci_req = 0;
        chk("R5 bus write first", d, 32'h1111_1111);
        prd(4'd1, d); chk("R5 module write next cycle", d, 32'h1111_2222);
    endtask

    task automatic t_override();
        logic [31:0] d;
        pci_req = 1; pci_we = 1; pci_word = 4'd15; pci_be_n = 4'h0; pci_wdata = 32'h4444_4444;
        mod_cs = 1; mod_we = 1; mod_word = 4'd15; mod_be_n = 4'h0; mod_wdata = 32'h5555_5555;
        @(negedge clk);
        mod_cs = 0; mod_we = 0; mod_be_n = 4'hF;
        pci_be_n = 4'b1100; pci_wdata = 32'h6666_6666;
        @(negedge clk);
        pci_req = 0; pci_we = 0; pci_be_n = 4'hF;
        prd(4'd15, d); chk("R6 bus lanes beat deferred write", d, 32'h5555_6666);
    endtask

    task automatic t_bar_format();
        logic [31:0] d;
        pwr(4'd4, 4'h0, 32'hFFFF_FFFF);
        prd(4'd4, d); chk("R7 bar low bits zero", d, 32'hFFFF_FFF1);
        pwr(4'd4, 4'h0, 32'h1000_000E);
        prd(4'd4, d); chk("R7 bar memory value", d, 32'h1000_0000);
    endtask

    task automatic t_decode_mem();
        logic [5:0] s;
        dec(32'h1000_000F, 1'b1, s); chk("R8 last byte in range", {26'd0, s}, 32'h1);
        dec(32'h1000_0010, 1'b1, s); chk("R8 past range end", {26'd0, s}, 0);
        @(negedge clk);
        chk("R8 idle after valid drops", {26'd0, dec_sel}, 0);
    endtask

    task automatic t_decode_io();
        logic [5:0] s;
        dec(32'h1000_0004, 1'b0, s); chk("R9 io access misses memory bar", {26'd0, s}, 0);
        mwr(4'd5, 4'h0, 32'h0000_2001);
        dec(32'h0000_2005, 1'b0, s); chk("R9 io bar hit", {26'd0, s}, 32'h2);
        dec(32'h0000_2005, 1'b1, s); chk("R9 memory access misses io bar", {26'd0, s}, 0);
    endtask

    task automatic t_zero_bar();
        logic [5:0] s;
        dec(32'h0000_0000, 1'b1, s); chk("R10 zero bars no mem hit", {26'd0, s}, 0);
        dec(32'h0000_0008, 1'b0, s); chk("R10 zero bars no io hit", {26'd0, s}, 0);
    endtask

    task automatic t_overlap();
        logic [5:0] s;
        mwr(4'd7, 4'h0, 32'h1000_0000);
        dec(32'h1000_0004, 1'b1, s); chk("R11 lowest index wins", {26'd0, s}, 32'h1);
        pwr(4'd9, 4'h0, 32'h3000_0000);
        dec(32'h3000_0008, 1'b1, s); chk("R11 top bar alone", {26'd0, s}, 32'h20);
    endtask

    task automatic t_unimpl();
        logic [31:0] d;
        pwr(4'd2, 4'h0, 32'hFFFF_FFFF);
        prd(4'd2, d); chk("R12 word2 ignores write", d, 0);
        mwr(4'd12, 4'h0, 32'h1234_5678);
        mrd(4'd12, d); chk("R12 word12 ignores write", d, 0);
        prd(4'd10, d); chk("R12 word10 zero", d, 0);
        pwr(4'd0, 4'h0, 32'h0);
        prd(4'd0, d); chk("R12 id word read-only", d, ID);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_lanes();
        t_cs_gate();
        t_collide();
        t_override();
        t_bar_format();
        t_decode_mem();
        t_decode_io();
        t_zero_bar();
        t_overlap();
        t_unimpl();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule